// File: doc/BRIEF.md
# Lane-Partitioned Multi-Mode Multiplier

This block is a two-stage pipelined multiplier that accepts a new operation on every clock. Each 32-bit operand pair can be treated as one 32-bit number, as two 16-bit lanes, or as four 8-bit lanes. In the 16-bit arrangement the block can return two independent products, a complex product (real part in the upper half of each operand), or the dot and cross products of two 2D vectors. In every arrangement, each operand has its own signed/unsigned select.

The datapath is built around a single array of sixteen byte-by-byte partial products. The operating mode only changes which bytes are sign-extended and how the partial products are summed, so every mode uses the same multipliers. A number-format select then scales each lane result in one of three ways: as an integer, as fixed point with optional round-to-nearest, or as normalised fixed point. In the normalised format, an all-ones lane value behaves as exactly 1.0. The results are packed into a 48-bit bus, and each lane has a fixed bit field.

Top module: `lanemul_top`

## Requirements
- R1: A result appears with `out_valid` high exactly two clock edges after the edge that samples `in_valid` high. Back-to-back issues produce results on consecutive cycles. Mode, format and sign selects are taken per issue, so a change applies to the next issued operation.
- R2: When `mode` is 0 (wide), the 32x32 product is formed exactly. In integer format, `result` is its low 48 bits.
- R3: When `mode` is 1 (pair), `result[47:24]` is the product of the upper 16-bit halves and `result[23:0]` is the product of the lower halves. Each is formatted to 24 bits.
- R4: When `mode` is 2 (complex), operand bits 31..16 are the real part and bits 15..0 are the imaginary part. `result[47:24]` = ar*br − ai*bi and `result[23:0]` = ar*bi + ai*br, each 24 bits.
- R5: When `mode` is 3 (vector), operand bits 31..16 are X and bits 15..0 are Y. `result[47:24]` = ax*bx + ay*by and `result[23:0]` = ax*by − ay*bx. Both are signed results, even when the operands are unsigned.
- R6: When `mode` is 4 (quad), byte k of A is multiplied by byte k of B. The result is formatted to 12 bits and placed at `result[12k+11:12k]`.
- R7: `a_signed` and `b_signed` independently select two's-complement or unsigned reading for every lane of their own operand.
- R8: When `fmt` is 1 (fixed), each lane value V of operand lane width W becomes (V + (rnd ? 2^(W/2−1) : 0)) >> W/2, using an arithmetic shift. The result is then truncated to the lane field. When `fmt` is 0 (integer), V is truncated without shifting.
- R9: When `fmt` is 2 (normalised), t = V + 2^(W−1) and the lane result is (t + (t >> W)) >> W. With unsigned operands, multiplying by an all-ones lane returns the other operand unchanged.
- R10: After a synchronous reset, `out_valid` is 0 and `result` is 0. While `out_valid` is low, `result` holds its last value.
- R11: The reserved `mode` values 5 to 7 act as wide mode, and the reserved `fmt` value 3 acts as integer format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| a_signed | input | 1 | Operand A lanes are two's complement |
| b_signed | input | 1 | Operand B lanes are two's complement |
| mode | input | 3 | 0 wide, 1 pair, 2 complex, 3 vector, 4 quad |
| fmt | input | 2 | 0 integer, 1 fixed, 2 normalised |
| rnd | input | 1 | Round to nearest in fixed format |
| out_valid | output | 1 | Result valid |
| result | output | 48 | Packed lane results |

## Verification
The assertions check on every cycle that:
- results arrive with the two-cycle latency and that the result holds while idle;
- a wide multiply by one returns the other operand;
- a zero lower pair lane yields a zero lower field;
- a normalised quad lane times 0xFF returns the other byte.

The lane arithmetic needs the bench's scenarios to be shown. Those scenarios cover the complex and vector sign combinations, mixed signedness, the fixed-point rounding boundary, the normalised identity at full width, the reserved-code fallbacks, and the mode switches between consecutive back-to-back issues.

// File: rtl/lanemul_pkg.sv
// Shared widths and control encodings for the lane-partitioned multiplier.
// Assumes the operand width is a multiple of 32 bits split into bytes.
package lanemul_pkg;
    localparam int OPW    = 32;             // operand width
    localparam int BW     = 8;              // byte lane width
    localparam int NBYTE  = OPW / BW;       // bytes per operand
    localparam int HW     = OPW / 2;        // half lane width
    localparam int RESW   = OPW * 3 / 2;    // packed result width
    localparam int PPW    = 2 * (BW + 1);   // signed byte product width
    localparam int FULLVW = 2 * OPW + 2;    // wide value width
    localparam int HALFVW = OPW + 3;        // half-lane value width
    localparam int QRW    = BW * 3 / 2;     // quad lane field width
    localparam int HRW    = HW * 3 / 2;     // half lane field width

    typedef enum logic [2:0] {
        MD_WIDE  = 3'd0,
        MD_PAIR  = 3'd1,
        MD_CMPLX = 3'd2,
        MD_VEC   = 3'd3,
        MD_QUAD  = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        FM_INT  = 2'd0,
        FM_FIX  = 2'd1,
        FM_NORM = 2'd2
    } fmt_e;

    typedef logic [NBYTE-1:0][NBYTE-1:0][PPW-1:0] pp_arr_t;
endpackage

// File: rtl/lanemul_ppgen.sv
// Byte partial-product array: every byte of A times every byte of B.
// The mode decides which bytes are the top byte of a lane; only those
// bytes are sign-extended (when their operand is signed), all others are
// zero-extended. Purely combinational; the caller registers the output.
module lanemul_ppgen
    import lanemul_pkg::*;
(
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    input  logic           a_signed,
    input  logic           b_signed,
    input  mode_e          mode,
    output pp_arr_t        pp
);
    // True when byte idx is the most significant byte of its lane.
    function automatic logic lane_top(input int idx, input mode_e m);
        case (m)
            MD_QUAD:                  return 1'b1;
            MD_PAIR, MD_CMPLX, MD_VEC: return (idx % 2) == 1;
            default:                  return idx == NBYTE - 1;
        endcase
    endfunction

    logic [NBYTE-1:0][BW:0] a_ext;
    logic [NBYTE-1:0][BW:0] b_ext;

    // Extend each byte by one bit according to lane position and signedness.
    always_comb begin
        for (int k = 0; k < NBYTE; k++) begin
            a_ext[k] = {a_signed & lane_top(k, mode) & op_a[k*BW+BW-1], op_a[k*BW +: BW]};
            b_ext[k] = {b_signed & lane_top(k, mode) & op_b[k*BW+BW-1], op_b[k*BW +: BW]};
        end
    end

    genvar gi, gj;
    generate
        for (gi = 0; gi < NBYTE; gi++) begin : g_row
            for (gj = 0; gj < NBYTE; gj++) begin : g_col
                // One signed 9x9 multiplier per byte pair.
                assign pp[gi][gj] = PPW'($signed(PPW'($signed(a_ext[gi])) * PPW'($signed(b_ext[gj]))));
            end
        end
    endgenerate
endmodule

// File: rtl/lanemul_scale.sv
// Formats one signed lane value into its result field.
// Integer: truncate. Fixed: optional half-LSB round, then drop W/2 bits.
// Normalised: round and fold so that an all-ones lane acts as 1.0.
// Assumes VW is wide enough to hold the exact lane value.
module lanemul_scale
    import lanemul_pkg::*;
#(
    parameter int W  = 8,
    parameter int R  = 12,
    parameter int VW = 18
) (
    input  logic signed [VW-1:0] val,
    input  fmt_e                 fmt,
    input  logic                 rnd,
    output logic [R-1:0]         res
);
    localparam int EW = VW + 2;
    localparam logic [EW-1:0] FIXHALF  = EW'(1) << (W/2 - 1);
    localparam logic [EW-1:0] NORMHALF = EW'(1) << (W - 1);

    logic signed [EW-1:0] ve;
    logic signed [EW-1:0] fx;
    logic signed [EW-1:0] tn;
    logic signed [EW-1:0] nrm;

    // Compute the three candidate scalings and pick one by format.
    always_comb begin
        ve  = EW'(val);
        fx  = (ve + (rnd ? $signed(FIXHALF) : '0)) >>> (W/2);
        tn  = ve + $signed(NORMHALF);
        nrm = (tn + (tn >>> W)) >>> W;
        case (fmt)
            FM_FIX:  res = fx[R-1:0];
            FM_NORM: res = nrm[R-1:0];
            default: res = ve[R-1:0];
        endcase
    end
endmodule

// File: rtl/lanemul_combine.sv
// Sums the registered byte partial products into the lane values of the
// selected mode and formats each lane. Wide mode uses all sixteen terms,
// half-lane modes use four 2x2 groups, quad mode uses the diagonal.
module lanemul_combine
    import lanemul_pkg::*;
(
    input  pp_arr_t          pp,
    input  mode_e            mode,
    input  fmt_e             fmt,
    input  logic             rnd,
    output logic [RESW-1:0]  res
);
    logic signed [FULLVW-1:0] wide_v;
    logic signed [HALFVW-1:0] hp [2][2];   // hp[x][y]: A half x times B half y
    logic signed [HALFVW-1:0] half_v [2];  // [1] upper field, [0] lower field
    logic [RESW-1:0]          wide_r;
    logic [HRW-1:0]           half_r [2];
    logic [QRW-1:0]           quad_r [NBYTE];

    // Full-width sum of all byte terms at their byte weights.
    always_comb begin
        wide_v = '0;
        for (int i = 0; i < NBYTE; i++)
            for (int j = 0; j < NBYTE; j++)
                wide_v = wide_v + (FULLVW'($signed(pp[i][j])) <<< (BW*(i+j)));
    end

    // Four half-lane cross products from 2x2 groups of byte terms.
    always_comb begin
        for (int x = 0; x < 2; x++)
            for (int y = 0; y < 2; y++) begin
                hp[x][y] = '0;
                for (int di = 0; di < 2; di++)
                    for (int dj = 0; dj < 2; dj++)
                        hp[x][y] = hp[x][y] +
                            (HALFVW'($signed(pp[2*x+di][2*y+dj])) <<< (BW*(di+dj)));
            end
    end

    // Select the half-lane combination required by the mode.
    always_comb begin
        case (mode)
            MD_CMPLX: begin
                half_v[1] = hp[1][1] - hp[0][0];
                half_v[0] = hp[1][0] + hp[0][1];
            end
            MD_VEC: begin
                half_v[1] = hp[1][1] + hp[0][0];
                half_v[0] = hp[1][0] - hp[0][1];
            end
            default: begin
                half_v[1] = hp[1][1];
                half_v[0] = hp[0][0];
            end
        endcase
    end

    lanemul_scale #(.W(OPW), .R(RESW), .VW(FULLVW)) u_wide_scale (
        .val(wide_v), .fmt(fmt), .rnd(rnd), .res(wide_r)
    );

    genvar gh, gq;
    generate
        for (gh = 0; gh < 2; gh++) begin : g_half
            lanemul_scale #(.W(HW), .R(HRW), .VW(HALFVW)) u_half_scale (
                .val(half_v[gh]), .fmt(fmt), .rnd(rnd), .res(half_r[gh])
            );
        end
        for (gq = 0; gq < NBYTE; gq++) begin : g_quad
            lanemul_scale #(.W(BW), .R(QRW), .VW(PPW)) u_quad_scale (
                .val($signed(pp[gq][gq])), .fmt(fmt), .rnd(rnd), .res(quad_r[gq])
            );
        end
    endgenerate

    // Pack lane fields onto the result bus by mode.
    always_comb begin
        case (mode)
            MD_QUAD: for (int k = 0; k < NBYTE; k++) res[k*QRW +: QRW] = quad_r[k];
            MD_PAIR, MD_CMPLX, MD_VEC: res = {half_r[1], half_r[0]};
            default: res = wide_r;
        endcase
    end
endmodule

// File: rtl/lanemul_top.sv
// Two-stage lane-partitioned multiplier. Stage 1 registers the byte
// partial products and the per-issue controls; stage 2 registers the
// combined, formatted result. One issue per cycle, latency two.
// Assumes in_valid is low while rst_n is low.
module lanemul_top
    import lanemul_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     op_a,
    input  logic [31:0]     op_b,
    input  logic            a_signed,
    input  logic            b_signed,
    input  logic [2:0]      mode,
    input  logic [1:0]      fmt,
    input  logic            rnd,
    output logic            out_valid,
    output logic [47:0]     result
);
    pp_arr_t         pp_c, s1_pp;
    logic            s1_valid;
    mode_e           s1_mode;
    fmt_e            s1_fmt;
    logic            s1_rnd;
    logic [RESW-1:0] comb_res;

    lanemul_ppgen u_ppgen (
        .op_a(op_a), .op_b(op_b), .a_signed(a_signed), .b_signed(b_signed),
        .mode(mode_e'(mode)), .pp(pp_c)
    );

    // Stage 1: capture partial products and controls of each issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_pp    <= '0;
            s1_mode  <= MD_WIDE;
            s1_fmt   <= FM_INT;
            s1_rnd   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_pp   <= pp_c;
                s1_mode <= mode_e'(mode);
                s1_fmt  <= fmt_e'(fmt);
                s1_rnd  <= rnd;
            end
        end
    end

    lanemul_combine u_combine (
        .pp(s1_pp), .mode(s1_mode), .fmt(s1_fmt), .rnd(s1_rnd), .res(comb_res)
    );

    // Stage 2: register the packed result; hold it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) result <= comb_res;
        end
    end

    // R1: each issue yields a valid result two edges later.
    a_r1_issue_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R1: no issue, no result two edges later.
    a_r1_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R10: result is held while no valid result is presented.
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(result));

    // R2: unsigned wide multiply by one returns the other operand.
    a_r2_wide_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd0 && fmt == 2'd0 && op_a == 32'd1 && !a_signed && !b_signed)
        |-> ##2 (result == {16'd0, $past(op_b, 2)}));

    // R3: a zero lower half of A gives a zero lower pair field.
    a_r3_pair_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd1 && fmt == 2'd0 && op_a[15:0] == 16'd0)
        |-> ##2 (result[23:0] == 24'd0));

    // R9: unsigned normalised quad lane 0 times 0xFF returns A's byte.
    a_r9_norm_one: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd4 && fmt == 2'd2 && !a_signed && !b_signed && op_b[7:0] == 8'hFF)
        |-> ##2 (result[11:0] == {4'd0, $past(op_a[7:0], 2)}));
endmodule

// File: tb/lanemul_top_bench.sv
`timescale 1ns/1ps
module lanemul_top_bench;
    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        as;
        logic        bs;
        logic [2:0]  md;
        logic [1:0]  fm;
        logic        rd;
        logic [47:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h00010001, 32'h0000FFFF, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 48'h0000FFFFFFFF, 4'd2},  // R2
        '{32'hFFFFFFFE, 32'h00000003, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0, 48'hFFFFFFFFFFFA, 4'd7},  // R7
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 48'hFFFE00000001, 4'd2},  // R2
        '{32'h00018000, 32'h00020000, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 48'h000000030000, 4'd8},  // R8
        '{32'h00000001, 32'h00008000, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 48'h000000000000, 4'd8},  // R8 truncate
        '{32'h00000001, 32'h00008000, 1'b0, 1'b0, 3'd0, 2'd1, 1'b1, 48'h000000000001, 4'd8},  // R8 round
        '{32'hFFFF0003, 32'h00020005, 1'b1, 1'b0, 3'd1, 2'd0, 1'b0, 48'hFFFFFE00000F, 4'd3},  // R3, R7
        '{32'hFFFF0100, 32'hFFFF0100, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 48'hFE0001010000, 4'd3},  // R3
        '{32'h00030002, 32'h0004FFFF, 1'b1, 1'b1, 3'd2, 2'd0, 1'b0, 48'h00000E000005, 4'd4},  // R4
        '{32'h00020005, 32'h0003FFFC, 1'b1, 1'b1, 3'd3, 2'd0, 1'b0, 48'hFFFFF2FFFFE9, 4'd5},  // R5
        '{32'h00030004, 32'h00050006, 1'b0, 1'b0, 3'd3, 2'd0, 1'b0, 48'h000027FFFFFE, 4'd5},  // R5
        '{32'h807F02FF, 32'h020203FF, 1'b1, 1'b0, 3'd4, 2'd0, 1'b0, 48'hF000FE006F01, 4'd6},  // R6
        '{32'h12FF8000, 32'hFFFF80FF, 1'b0, 1'b0, 3'd4, 2'd2, 1'b0, 48'h0120FF040000, 4'd9},  // R9
        '{32'h01000180, 32'h02000101, 1'b0, 1'b0, 3'd1, 2'd1, 1'b1, 48'h000200000182, 4'd8},  // R8
        '{32'hFFFFFFFF, 32'h12345678, 1'b0, 1'b0, 3'd0, 2'd2, 1'b0, 48'h000012345678, 4'd9},  // R9
        '{32'h00000007, 32'h00000006, 1'b0, 1'b0, 3'd5, 2'd3, 1'b0, 48'h00000000002A, 4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic        a_signed, b_signed;
    logic [2:0]  mode;
    logic [1:0]  fmt;
    logic        rnd;
    logic        out_valid;
    logic [47:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    lanemul_top u_lanemul_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .a_signed(a_signed), .b_signed(b_signed), .mode(mode), .fmt(fmt), .rnd(rnd),
        .out_valid(out_valid), .result(result)
    );

    task automatic check(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        op_a = v.a; op_b = v.b; a_signed = v.as; b_signed = v.bs;
        mode = v.md; fmt = v.fm; rnd = v.rd;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string tag;
        tag = $sformatf("R%0d vector %0d", v.req, idx);
        check(out_valid === 1'b1, {tag, " out_valid"}, 48'(out_valid), 48'd1);
        check(result === v.exp, tag, result, v.exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] held;
        rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
        a_signed = 1'b0; b_signed = 1'b0; mode = '0; fmt = '0; rnd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(out_valid === 1'b0, "R10 reset out_valid", 48'(out_valid), 48'd0);
        check(result === 48'd0, "R10 reset result", result, 48'd0);

        // Table walk: issue, drop, sample two edges after issue.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check_vec(VECS[i], i);
        end

        // R1: back-to-back issues with a mode change on every cycle.
        drive(VECS[8]);
        @(negedge clk);
        drive(VECS[11]);
        @(negedge clk);
        check_vec(VECS[8], 8);
        drive(VECS[0]);
        @(negedge clk);
        check(result === VECS[11].exp, "R1 back-to-back second", result, VECS[11].exp);
        in_valid = 1'b0;
        @(negedge clk);
        check(result === VECS[0].exp, "R1 back-to-back third", result, VECS[0].exp);
        check(out_valid === 1'b1, "R1 back-to-back third valid", 48'(out_valid), 48'd1);

        // R10: idle cycles keep the last result, with operands changing.
        held = result;
        op_a = 32'hDEADBEEF; op_b = 32'h0BADF00D; mode = 3'd4;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R10 idle out_valid", 48'(out_valid), 48'd0);
        check(result === held, "R10 idle hold", result, held);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule